// File: doc/BRIEF.md
# Sync Input Field Detector

This block runs on the double-pixel-rate clock and watches horizontal and vertical sync signals that come from outside the chip. Each vertical sync pulse starts a new field. The block decides whether that field is odd or even from how close the horizontal sync leading edge lies to the vertical sync leading edge. If the two leading edges are within 127 clocks of each other, in either order, the field is odd. Otherwise it is even. The result is presented on a single field output.

Each sync input has its own programmable active level. A pulse is only accepted when it stays active on at least two consecutive clock samples, so a one-sample glitch is discarded. A horizontal edge may arrive up to 127 clocks after the vertical edge, so the decision is held open until that window closes. The new field value is then presented a fixed number of clocks after the vertical leading edge. That number depends on whether blanking is supplied from outside or driven by the encoder.

Top module: `sync_field_det`

## Requirements
- R1: `hs_act_high_i` and `vs_act_high_i` give the active level of their sync input: 1 means active high, 0 means active low.
- R2: A sync pulse is accepted only if it is sampled active on at least two consecutive rising edges. Its leading edge is the first of those edges.
- R3: The field is odd when an accepted HSYNC leading edge lies no more than 127 edges before or after the accepted VSYNC leading edge. A distance of 0 counts as odd.
- R4: The field is even when no accepted HSYNC leading edge lies within 127 edges of the VSYNC leading edge. This includes a distance of 128 on either side and an HSYNC pulse that was too short to be accepted.
- R5: `field_o` is 0 for an odd field and 1 for an even field, and it is 0 after reset.
- R6: Let V be the rising edge that samples the VSYNC leading edge. `field_o` takes its new value on edge V+148 when `blank_out_i` is 0, and on edge V+138 when `blank_out_i` is 1. It holds its previous value up to and including the edge before.
- R7: A VSYNC pulse that is active for only one sample leaves `field_o` unchanged.
- R8: An HSYNC leading edge that arrives more than 127 edges after the VSYNC leading edge, while the result is still pending, has no effect on the pending decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2_i | input | 1 | Clock at twice the pixel rate |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hsync_i | input | 1 | External horizontal sync |
| vsync_i | input | 1 | External vertical sync |
| hs_act_high_i | input | 1 | Active level of `hsync_i` (1 = active high) |
| vs_act_high_i | input | 1 | Active level of `vsync_i` (1 = active high) |
| blank_out_i | input | 1 | 1 when blanking is driven by the encoder; selects the shorter field latency |
| field_o | output | 1 | Field indicator: 0 = odd, 1 = even |

## Verification
The hardest cases to reach from the ports are the window edges. An HSYNC edge exactly 127 or 128 clocks before VSYNC depends on the saturating age counter. One exactly 127 or 128 clocks after VSYNC falls while the decision is still pending, and the result only shows well over a hundred clocks later. The bench therefore places every pulse at an absolute edge index relative to the VSYNC leading edge. It sweeps the HSYNC offset through both window edges and a stride of interior points, under both latency settings and both polarities. It checks `field_o` on the edge before and on the edge at the stated latency. The expected values are ordered so that consecutive fields alternate where possible, which exposes a stuck output.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic {
    FIELD_ODD  = 1'b0,
    FIELD_EVEN = 1'b1
  } field_e;

  localparam int unsigned SYNC_H = 0;
  localparam int unsigned SYNC_V = 1;
  localparam int unsigned N_SYNC = 2;
endpackage

// File: rtl/fd_pulse_qual.sv
module fd_pulse_qual #(
  parameter int unsigned MIN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic act_o,
  output logic qual_o
);
  localparam int unsigned RUN_W = $clog2(MIN_W + 1);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(MIN_W);
  localparam logic [RUN_W-1:0] RUN_HIT  = RUN_W'(MIN_W - 1);

  logic             act_q;
  logic [RUN_W-1:0] run_q, run_n;
  logic             run_en;

  always_comb begin
    run_en = 1'b1;
    if (!act_q)                run_n = '0;
    else if (run_q != RUN_SAT) run_n = run_q + 1'b1;
    else begin
      run_n  = run_q;
      run_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      run_q <= '0;
    end else begin
      act_q <= act_i;
      if (run_en) run_q <= run_n;
    end
  end

  assign act_o  = act_q;
  assign qual_o = act_q && (run_q == RUN_HIT);
endmodule

// File: rtl/fd_hs_age.sv
module fd_hs_age #(
  parameter int unsigned WIN = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hs_qual_i,
  output logic [$clog2(WIN+2)-1:0]   age_o,
  output logic                       near_o
);
  localparam int unsigned AGE_W = $clog2(WIN + 2);
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(WIN + 1);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(WIN);

  logic [AGE_W-1:0] age_q, age_n;
  logic             age_en;

  always_comb begin
    age_en = 1'b1;
    if (hs_qual_i)             age_n = '0;
    else if (age_q != AGE_SAT) age_n = age_q + 1'b1;
    else begin
      age_n  = age_q;
      age_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= AGE_SAT;
    else if (age_en) age_q <= age_n;
  end

  assign age_o  = age_q;
  assign near_o = hs_qual_i || (age_q < AGE_LIM);
endmodule

// File: rtl/fd_field_ctrl.sv
module fd_field_ctrl
  import fd_pkg::*;
#(
  parameter int unsigned WIN      = 127,
  parameter int unsigned MIN_W    = 2,
  parameter int unsigned LAT_BIN  = 148,
  parameter int unsigned LAT_BOUT = 138,
  parameter int unsigned CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vs_qual_i,
  input  logic             hs_qual_i,
  input  logic             near_i,
  input  logic             blank_out_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] since_o,
  output field_e           field_o
);
  localparam logic [CNT_W-1:0] LAST_BIN  = CNT_W'(LAT_BIN - MIN_W - 1);
  localparam logic [CNT_W-1:0] LAST_BOUT = CNT_W'(LAT_BOUT - MIN_W - 1);
  localparam logic [CNT_W-1:0] WIN_C     = CNT_W'(WIN);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] since_q, since_n;
  logic             odd_q, odd_n;
  field_e           field_q, field_n;
  logic [CNT_W-1:0] last_c;
  logic             commit;

  always_comb begin
    last_c  = blank_out_i ? LAST_BOUT : LAST_BIN;
    commit  = busy_q && (since_q == last_c);
    busy_n  = busy_q;
    since_n = since_q;
    odd_n   = odd_q;
    field_n = field_q;
    if (busy_q) begin
      if (hs_qual_i && (since_q < WIN_C)) odd_n = 1'b1;
      if (commit) begin
        field_n = odd_q ? FIELD_ODD : FIELD_EVEN;
        busy_n  = 1'b0;
      end else begin
        since_n = since_q + 1'b1;
      end
    end
    if (vs_qual_i) begin
      busy_n  = 1'b1;
      since_n = '0;
      odd_n   = near_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      since_q <= '0;
      odd_q   <= 1'b0;
      field_q <= FIELD_ODD;
    end else begin
      busy_q  <= busy_n;
      since_q <= since_n;
      odd_q   <= odd_n;
      field_q <= field_n;
    end
  end

  assign busy_o  = busy_q;
  assign since_o = since_q;
  assign field_o = field_q;
endmodule

// File: rtl/sync_field_det.sv
module sync_field_det
  import fd_pkg::*;
#(
  parameter int unsigned WIN      = 127,
  parameter int unsigned MIN_W    = 2,
  parameter int unsigned LAT_BIN  = 148,
  parameter int unsigned LAT_BOUT = 138
) (
  input  logic clk2_i,
  input  logic rst_n_i,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic hs_act_high_i,
  input  logic vs_act_high_i,
  input  logic blank_out_i,
  output logic field_o
);
  localparam int unsigned LAT_MAX = (LAT_BIN > LAT_BOUT) ? LAT_BIN : LAT_BOUT;
  localparam int unsigned CNT_W   = $clog2(LAT_MAX + 1);
  localparam int unsigned AGE_W   = $clog2(WIN + 2);

  logic              rst_meta, rst_n_s;
  logic [N_SYNC-1:0] sync_raw, sync_act, sync_qual;
  logic [AGE_W-1:0]  hs_age;
  logic              hs_near;
  logic              win_busy;
  logic [CNT_W-1:0]  since_vs;
  field_e            field_s;

  always_ff @(posedge clk2_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign sync_raw[SYNC_H] = (hsync_i == hs_act_high_i);
  assign sync_raw[SYNC_V] = (vsync_i == vs_act_high_i);

  for (genvar g = 0; g < N_SYNC; g++) begin : g_qual
    fd_pulse_qual #(.MIN_W(MIN_W)) u_qual (
      .clk    (clk2_i),
      .rst_n  (rst_n_s),
      .act_i  (sync_raw[g]),
      .act_o  (sync_act[g]),
      .qual_o (sync_qual[g])
    );
  end

  fd_hs_age #(.WIN(WIN)) u_age (
    .clk       (clk2_i),
    .rst_n     (rst_n_s),
    .hs_qual_i (sync_qual[SYNC_H]),
    .age_o     (hs_age),
    .near_o    (hs_near)
  );

  fd_field_ctrl #(
    .WIN(WIN), .MIN_W(MIN_W), .LAT_BIN(LAT_BIN), .LAT_BOUT(LAT_BOUT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk         (clk2_i),
    .rst_n       (rst_n_s),
    .vs_qual_i   (sync_qual[SYNC_V]),
    .hs_qual_i   (sync_qual[SYNC_H]),
    .near_i      (hs_near),
    .blank_out_i (blank_out_i),
    .busy_o      (win_busy),
    .since_o     (since_vs),
    .field_o     (field_s)
  );

  assign field_o = field_s;
endmodule

// File: rtl/sync_field_det_chk.sv
module sync_field_det_chk #(
  parameter int unsigned WIN   = 127,
  parameter int unsigned AGE_W = 7,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       act,
  input logic [1:0]       qual,
  input logic [AGE_W-1:0] age,
  input logic             busy,
  input logic [CNT_W-1:0] since,
  input logic             field
);
  assert_qual_needs_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    qual[1] |-> (act[1] && $past(act[1])));

  assert_qual_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    qual[0] |=> !qual[0]);

  assert_age_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    age <= AGE_W'(WIN + 1));

  assert_field_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (field != $past(field)) |-> $past(busy));

  assert_short_vs_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !act[1]) |=> !busy);

  assert_since_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (since == '0));
endmodule

bind sync_field_det sync_field_det_chk #(
  .WIN(WIN), .AGE_W(AGE_W), .CNT_W(CNT_W)
) u_chk (
  .clk   (clk2_i),
  .rst_n (rst_n_s),
  .act   (sync_act),
  .qual  (sync_qual),
  .age   (hs_age),
  .busy  (win_busy),
  .since (since_vs),
  .field (field_o)
);

// File: tb/sync_field_det_tb.sv
module sync_field_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_BIN    = 148;
  localparam int LAT_BOUT   = 138;
  localparam int WIN        = 127;

  logic clk2 = 1'b0;
  logic rst_n;
  logic hsync, vsync, hs_pol, vs_pol, bout;
  logic field;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic exp_field;

  sync_field_det u_dut (
    .clk2_i        (clk2),
    .rst_n_i       (rst_n),
    .hsync_i       (hsync),
    .vsync_i       (vsync),
    .hs_act_high_i (hs_pol),
    .vs_act_high_i (vs_pol),
    .blank_out_i   (bout),
    .field_o       (field)
  );

  always #(CLK_PERIOD/2) clk2 = ~clk2;

  task automatic check(input string req, input logic act, input logic expv, input int dh);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s dh=%0d bout=%0d: field_o=%0b expected %0b", req, dh, bout, act, expv);
    end
  endtask

  // Run one field: VSYNC leading edge sampled at edge 0, HSYNC at edge dh.
  task automatic frame(input int dh, input int wh, input int wv, input bit b);
    int lat;
    logic newf, oldf;
    bit odd;
    bout = b;
    lat  = b ? LAT_BOUT : LAT_BIN;
    odd  = (wh >= 2) && (dh <= WIN) && (dh >= -WIN);
    oldf = exp_field;
    newf = (wv >= 2) ? (odd ? 1'b0 : 1'b1) : oldf;
    for (int i = -200; i <= lat + 4; i++) begin
      @(negedge clk2);
      hsync = ((i >= dh) && (i < dh + wh)) ? hs_pol : ~hs_pol;
      vsync = ((i >= 0) && (i < wv)) ? vs_pol : ~vs_pol;
      @(posedge clk2);
      #(CLK_PERIOD/4);
      if (i == lat - 1) check("R6 hold before latency", field, oldf, dh);
      if (i == lat) begin
        if (wv < 2)            check("R7 short vsync", field, newf, dh);
        else if (wh < 2)       check("R4 short hsync gives even", field, newf, dh);
        else if (dh > WIN)     check("R8 late hsync ignored", field, newf, dh);
        else if (odd)          check("R3 odd within window", field, newf, dh);
        else                   check("R4 even outside window", field, newf, dh);
      end
    end
    exp_field = newf;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int edges[12] = '{-129, -128, -127, -126, -1, 0, 1, 5, 126, 127, 128, 129};
    rst_n = 1'b0; hs_pol = 1'b0; vs_pol = 1'b0; bout = 1'b0;
    hsync = 1'b1; vsync = 1'b1;
    exp_field = 1'b0;
    repeat (4) @(posedge clk2);
    @(negedge clk2);
    check("R5 reset value", field, 1'b0, 0);
    rst_n = 1'b1;
    repeat (6) @(posedge clk2);
    @(negedge clk2);
    check("R5 odd after reset", field, 1'b0, 0);

    // boundary sweep, both latencies, alternating with a far-away HSYNC
    for (int b = 0; b < 2; b++) begin
      foreach (edges[k]) begin
        frame(edges[k], 3, 4, b[0]);
        frame(190, 3, 4, b[0]);
      end
    end
    // interior stride sweep
    for (int d = -140; d <= 140; d += 20) frame(d, 2, 3, d[5]);
    // minimum width: one-sample HSYNC / VSYNC
    frame(0, 2, 3, 1'b0);
    frame(0, 1, 3, 1'b0);
    frame(10, 3, 3, 1'b1);
    frame(200, 3, 1, 1'b1);
    frame(-50, 3, 1, 1'b0);
    // R1: active-high polarity on both syncs
    hs_pol = 1'b1; vs_pol = 1'b1;
    frame(30, 3, 3, 1'b0);
    frame(-130, 3, 3, 1'b1);
    frame(-3, 4, 5, 1'b1);
    frame(80, 4, 5, 1'b0);
    // mixed polarity (R1)
    hs_pol = 1'b0; vs_pol = 1'b1;
    frame(150, 3, 3, 1'b0);
    frame(-60, 3, 3, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule